// File: doc/BRIEF.md
# MQ-Register Arithmetic Unit

This block is a 32-bit integer execution unit for a family of older instructions that use an extra multiplier-quotient (MQ) register next to the normal operands. One start pulse launches an operation on operands `a` and `b`. The unit returns a result word, updates the internal MQ register where the operation defines it, and raises `done` for one cycle. The MQ register serves three purposes: it supplies the low half of a 64-bit dividend, it receives a remainder, and it receives the upper half of a product. It can also be loaded directly.

Divides run on a restoring divider that produces one quotient bit per cycle and holds `busy` while it works. All other operations, and divides whose outcome is fixed by a special case, finish in one cycle. Each operation has a recording form that writes the overflow flag `ovf` and folds it into a sticky summary flag `sovf`. Only the dedicated `sovf_clr` input clears the summary flag.

Top module: `mq_alu`

## Requirements
- R1: After reset, `result`, `mq`, `ovf`, `sovf`, `busy` and `done` are all 0.
- R2: Operation code bits [2:0] select the function: 0 long divide, 1 short divide, 2 multiply, 3 negate-with-saturation, 4 difference-or-zero, 5 mask generation, 6 and 7 load MQ. When bit 3 is 1 the operation records overflow: `ovf` takes the operation's overflow value and `sovf` is set if that value is 1. When bit 3 is 0, `ovf` and `sovf` are left unchanged.
- R3: Long divide treats {a, MQ} as a signed 64-bit dividend and divides it by signed `b`, truncating toward zero. `result` gets the low 32 bits of the quotient and MQ gets the remainder, which carries the dividend's sign. The overflow value is 1 when the quotient lies outside the signed 32-bit range.
- R4: A divide is a special case when `b` is 0. For long divide it is also a special case when the dividend magnitude divided by 2^32 is at least |b|. For short divide it is also a special case when `a` = 0x80000000 and `b` = 0xFFFFFFFF. In a special case, `result` is bit 31 of `a` copied into all 32 bits, MQ becomes 0, and the overflow value is 1.
- R5: Short divide divides signed `a` by signed `b`, truncating toward zero. `result` gets the quotient and MQ gets the remainder. Outside the special cases the overflow value is 0.
- R6: Multiply forms the signed 64-bit product of `a` and `b`. MQ gets the upper 32 bits and `result` the lower 32 bits. The overflow value is 1 when the upper half is not the sign extension of the lower half.
- R7: Negate-with-saturation returns 0x7FFFFFFF with overflow value 1 when `a` = 0x80000000. For any other `a` it returns the two's-complement negation of `a` with overflow value 0. MQ is unchanged.
- R8: Difference-or-zero returns `b` − `a` when signed `b` > signed `a`, and 0 otherwise. The overflow value is 1 only when that subtraction overflows in signed arithmetic. MQ is unchanged.
- R9: Mask generation takes a start index from `a[4:0]` and a stop index from `b[4:0]`, with index 0 naming result bit 31. Bit positions from start to stop inclusive are set to 1. When start > stop the run wraps past index 31 back to index 0, so start = stop+1 gives all ones. MQ is unchanged and the overflow value is 0.
- R10: Load MQ copies `a` into both MQ and `result`, with overflow value 0.
- R11: `sovf` never goes from 1 to 0 except in the cycle after `sovf_clr` is high.
- R12: `done` is high in the cycle after the start cycle for non-iterative operations, including special-case divides. An iterative divide raises `done` 33 cycles after its start cycle and holds `busy` in the 32 cycles between.
- R13: A `start` while `busy` is high is ignored. The running divide completes with its own results, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse for the operation on `op`, `a`, `b` |
| op | input | 4 | Bit 3 records overflow; bits [2:0] select the function |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| sovf_clr | input | 1 | Clears the sticky summary overflow |
| result | output | 32 | Result of the last completed operation |
| mq | output | 32 | Current MQ register |
| ovf | output | 1 | Overflow from the last recording operation |
| sovf | output | 1 | Sticky summary overflow |
| busy | output | 1 | Iterative divide in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker checks four things on every cycle: that `sovf` can only fall after a clear, that a rising `ovf` is always accompanied by `sovf`, that outputs stay frozen while a divide iterates, and that every `done` follows a start or the end of a busy window exactly 32 cycles long. The arithmetic cannot be judged cycle by cycle. The bench's scenarios compare each function against independently computed values. These cover signed divide remainders, the two kinds of divide special case, quotient overflow without a special case, wrapping masks, saturating negation, and a start injected mid-divide.

// File: rtl/mq_alu_pkg.sv
package mq_alu_pkg;

    localparam int XLEN = 32;
    localparam int OPW  = 4;

    typedef enum logic [2:0] {
        FN_DIVL  = 3'd0,
        FN_DIVS  = 3'd1,
        FN_MUL   = 3'd2,
        FN_NEG   = 3'd3,
        FN_DOZ   = 3'd4,
        FN_MASK  = 3'd5,
        FN_LDMQ  = 3'd6,
        FN_LDMQ2 = 3'd7
    } fn_e;

    typedef struct packed {
        logic rec;
        fn_e  fn;
    } opsel_t;

    function automatic opsel_t decode_op(input logic [OPW-1:0] op);
        opsel_t s;
        s.rec = op[OPW-1];
        s.fn  = fn_e'(op[2:0]);
        return s;
    endfunction

    function automatic logic is_divide(input fn_e fn);
        return (fn == FN_DIVL) || (fn == FN_DIVS);
    endfunction

endpackage

// File: rtl/mq_fastops.sv
module mq_fastops
    import mq_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  fn_e          fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic [W-1:0] mq_val,
    output logic         mq_we,
    output logic         ov
);
    localparam int SW = $clog2(W);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    logic signed [2*W-1:0] prod;
    logic [W-1:0]          diff;
    logic                  diff_ov;
    logic                  b_gt_a;
    logic [W-1:0]          mask;
    logic [SW-1:0]         m_first;
    logic [SW-1:0]         m_last;

    assign prod    = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    assign diff    = b - a;
    assign diff_ov = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ b[W-1]);
    assign b_gt_a  = $signed(b) > $signed(a);
    assign m_first = a[SW-1:0];
    assign m_last  = b[SW-1:0];

    for (genvar i = 0; i < W; i++) begin : g_mask
        localparam logic [SW-1:0] IDX = SW'(i);
        assign mask[W-1-i] = (m_first <= m_last) ? ((IDX >= m_first) && (IDX <= m_last))
                                                 : ((IDX >= m_first) || (IDX <= m_last));
    end

    always_comb begin
        res    = '0;
        mq_val = '0;
        mq_we  = 1'b0;
        ov     = 1'b0;
        case (fn)
            FN_MUL: begin
                res    = prod[W-1:0];
                mq_val = prod[2*W-1:W];
                mq_we  = 1'b1;
                ov     = (prod[2*W-1:W] != {W{prod[W-1]}});
            end
            FN_NEG: begin
                if (a == MOST_NEG) begin
                    res = MOST_POS;
                    ov  = 1'b1;
                end else begin
                    res = ~a + W'(1);
                end
            end
            FN_DOZ: begin
                if (b_gt_a) begin
                    res = diff;
                    ov  = diff_ov;
                end
            end
            FN_MASK: res = mask;
            FN_LDMQ, FN_LDMQ2: begin
                res    = a;
                mq_val = a;
                mq_we  = 1'b1;
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/mq_div_iter.sv
module mq_div_iter
    import mq_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [2*W-1:0] dvd_mag,
    input  logic [W-1:0]   dsr_mag,
    output logic           busy,
    output logic           fin,
    output logic [W-1:0]   q_mag,
    output logic [W-1:0]   r_mag
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dsr_q;
    logic [CW-1:0] cnt_q;
    logic          act_q;

    logic [W:0]    trial;
    logic [W:0]    sub;
    logic          take;
    logic [W-1:0]  rem_nx;
    logic [W-1:0]  quo_nx;

    assign trial  = {rem_q, quo_q[W-1]};
    assign sub    = trial - {1'b0, dsr_q};
    assign take   = ~sub[W];
    assign rem_nx = take ? sub[W-1:0] : trial[W-1:0];
    assign quo_nx = {quo_q[W-2:0], take};

    assign busy  = act_q;
    assign fin   = act_q && (cnt_q == CW'(1));
    assign q_mag = quo_nx;
    assign r_mag = rem_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (go && !act_q) begin
            rem_q <= dvd_mag[2*W-1:W];
            quo_q <= dvd_mag[W-1:0];
            dsr_q <= dsr_mag;
            cnt_q <= CW'(W);
            act_q <= 1'b1;
        end else if (act_q) begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
                act_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mq_alu.sv
module mq_alu
    import mq_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sovf_clr,
    output logic [W-1:0]   result,
    output logic [W-1:0]   mq,
    output logic           ovf,
    output logic           sovf,
    output logic           busy,
    output logic           done
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    opsel_t         sel;
    logic           div_op;
    logic           long_op;
    logic [2*W-1:0] dvd;
    logic           dvd_neg;
    logic [2*W-1:0] dmag;
    logic [W-1:0]   bmag;
    logic           special;
    logic           accept;
    logic           go;

    logic [W-1:0]   f_res;
    logic [W-1:0]   f_mq;
    logic           f_mq_we;
    logic           f_ov;

    logic           d_busy;
    logic           d_fin;
    logic [W-1:0]   q_mag;
    logic [W-1:0]   r_mag;

    logic [W-1:0]   result_q;
    logic [W-1:0]   mq_q;
    logic           ovf_q;
    logic           sovf_q;
    logic           done_q;
    logic           pq_neg;
    logic           pr_neg;
    logic           p_long;
    logic           p_rec;

    logic           wr;
    logic           wr_rec;
    logic           wr_ov;
    logic           wr_mq;
    logic [W-1:0]   n_res;
    logic [W-1:0]   n_mq;
    logic [W-1:0]   q_signed;
    logic [W-1:0]   r_signed;
    logic           q_wide;

    assign sel     = decode_op(op);
    assign div_op  = is_divide(sel.fn);
    assign long_op = (sel.fn == FN_DIVL);
    assign dvd     = long_op ? {a, mq_q} : {{W{a[W-1]}}, a};
    assign dvd_neg = dvd[2*W-1];
    assign dmag    = dvd_neg ? (~dvd + (2*W)'(1)) : dvd;
    assign bmag    = b[W-1] ? (~b + W'(1)) : b;
    assign special = long_op ? (dmag[2*W-1:W] >= bmag)
                             : ((b == '0) || ((a == MOST_NEG) && (b == '1)));
    assign accept  = start && !d_busy;
    assign go      = accept && div_op && !special;

    mq_fastops #(.W(W)) u_fast (
        .fn     (sel.fn),
        .a      (a),
        .b      (b),
        .res    (f_res),
        .mq_val (f_mq),
        .mq_we  (f_mq_we),
        .ov     (f_ov)
    );

    mq_div_iter #(.W(W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .dvd_mag (dmag),
        .dsr_mag (bmag),
        .busy    (d_busy),
        .fin     (d_fin),
        .q_mag   (q_mag),
        .r_mag   (r_mag)
    );

    assign q_signed = pq_neg ? (~q_mag + W'(1)) : q_mag;
    assign r_signed = pr_neg ? (~r_mag + W'(1)) : r_mag;
    assign q_wide   = pq_neg ? (q_mag > MOST_NEG) : q_mag[W-1];

    always_comb begin
        wr     = 1'b0;
        wr_rec = 1'b0;
        wr_ov  = 1'b0;
        wr_mq  = 1'b0;
        n_res  = result_q;
        n_mq   = mq_q;
        if (d_fin) begin
            wr     = 1'b1;
            wr_rec = p_rec;
            wr_ov  = p_long & q_wide;
            wr_mq  = 1'b1;
            n_res  = q_signed;
            n_mq   = r_signed;
        end else if (accept && !go) begin
            wr     = 1'b1;
            wr_rec = sel.rec;
            if (div_op) begin
                wr_ov = 1'b1;
                wr_mq = 1'b1;
                n_res = {W{a[W-1]}};
                n_mq  = '0;
            end else begin
                wr_ov = f_ov;
                wr_mq = f_mq_we;
                n_res = f_res;
                n_mq  = f_mq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            mq_q     <= '0;
            ovf_q    <= 1'b0;
            sovf_q   <= 1'b0;
            done_q   <= 1'b0;
            pq_neg   <= 1'b0;
            pr_neg   <= 1'b0;
            p_long   <= 1'b0;
            p_rec    <= 1'b0;
        end else begin
            done_q <= wr;
            sovf_q <= (sovf_q & ~sovf_clr) | (wr & wr_rec & wr_ov);
            if (wr) begin
                result_q <= n_res;
            end
            if (wr && wr_mq) begin
                mq_q <= n_mq;
            end
            if (wr && wr_rec) begin
                ovf_q <= wr_ov;
            end
            if (go) begin
                pq_neg <= dvd_neg ^ b[W-1];
                pr_neg <= dvd_neg;
                p_long <= long_op;
                p_rec  <= sel.rec;
            end
        end
    end

    assign result = result_q;
    assign mq     = mq_q;
    assign ovf    = ovf_q;
    assign sovf   = sovf_q;
    assign busy   = d_busy;
    assign done   = done_q;

endmodule

// File: rtl/mq_alu_chk.sv
module mq_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         sovf_clr,
    input logic [W-1:0] result,
    input logic [W-1:0] mq,
    input logic         ovf,
    input logic         sovf,
    input logic         busy,
    input logic         done
);
    localparam int CW = $clog2(W + 2) + 1;

    logic [CW-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= '0;
        end else begin
            busy_run <= busy ? busy_run + CW'(1) : '0;
        end
    end

    AST_SOVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sovf && !sovf_clr) |=> sovf);                                   // R11

    AST_OVF_FEEDS_SOVF: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> sovf);                                            // R2

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($stable(result) && $stable(mq)));                      // R13

    AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);                                                 // R12

    AST_DIV_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (done && $past(busy)) |-> (busy_run == CW'(W)));                 // R12

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(start) || $past(busy)));                         // R13

endmodule

bind mq_alu mq_alu_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sovf_clr (sovf_clr),
    .result   (result),
    .mq       (mq),
    .ovf      (ovf),
    .sovf     (sovf),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_mq_alu.sv
`timescale 1ns/1ps
module tb_mq_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        sovf_clr = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [31:0] result;
    logic [31:0] mq;
    logic        ovf;
    logic        sovf;
    logic        busy;
    logic        done;

    int checks = 0;
    int fails  = 0;
    logic [31:0] sh_mq = '0;
    logic        sh_ov = 1'b0;
    logic        sh_so = 1'b0;

    always #2.5 clk = ~clk;

    mq_alu dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
        .sovf_clr(sovf_clr), .result(result), .mq(mq), .ovf(ovf),
        .sovf(sovf), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                         input logic [31:0] mqi, output logic [31:0] r, output logic [31:0] m,
                         output logic ovv, output int lat);
        longint dvd, q, rr, p, d;
        longint unsigned dm, bm;
        int first, last;
        m = mqi; ovv = 1'b0; lat = 1; r = '0;
        case (o[2:0])
            3'd0: begin
                dvd = $signed({x, mqi});
                dm  = (dvd < 0) ? longint'(-dvd) : longint'(dvd);
                bm  = {32'd0, (y[31] ? -y : y)};
                if ((dm >> 32) >= bm) begin
                    r = {32{x[31]}}; m = '0; ovv = 1'b1;
                end else begin
                    q = dvd / longint'($signed(y));
                    rr = dvd % longint'($signed(y));
                    r = q[31:0]; m = rr[31:0]; lat = 33;
                    ovv = (q > 64'sd2147483647) || (q < -64'sd2147483648);
                end
            end
            3'd1: begin
                if (y == 0 || (x == 32'h80000000 && y == 32'hFFFFFFFF)) begin
                    r = {32{x[31]}}; m = '0; ovv = 1'b1;
                end else begin
                    q = longint'($signed(x)) / longint'($signed(y));
                    rr = longint'($signed(x)) % longint'($signed(y));
                    r = q[31:0]; m = rr[31:0]; lat = 33;
                end
            end
            3'd2: begin
                p = longint'($signed(x)) * longint'($signed(y));
                r = p[31:0]; m = p[63:32];
                ovv = (p != longint'($signed(p[31:0])));
            end
            3'd3: begin
                if (x == 32'h80000000) begin r = 32'h7FFFFFFF; ovv = 1'b1; end
                else r = 32'd0 - x;
            end
            3'd4: begin
                if ($signed(y) > $signed(x)) begin
                    d = longint'($signed(y)) - longint'($signed(x));
                    r = d[31:0];
                    ovv = (d > 64'sd2147483647) || (d < -64'sd2147483648);
                end
            end
            3'd5: begin
                first = int'(x[4:0]); last = int'(y[4:0]);
                for (int i = 0; i < 32; i++) begin
                    if (first <= last) r[31-i] = (i >= first) && (i <= last);
                    else               r[31-i] = (i >= first) || (i <= last);
                end
            end
            default: begin r = x; m = x; end
        endcase
    endtask

    task automatic apply(input string tag, input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] er, em;
        logic eov;
        int elat, lat;
        model(o, x, y, sh_mq, er, em, eov, elat);
        @(negedge clk);
        op = o; a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        sh_mq = em;
        if (o[3]) begin
            sh_ov = eov;
            if (eov) sh_so = 1'b1;
        end
        chk({tag, " R12 latency"}, 32'(lat), 32'(elat));
        chk({tag, " result"}, result, er);
        chk({tag, " mq"}, mq, sh_mq);
        chk({tag, " R2 ovf"}, {31'd0, ovf}, {31'd0, sh_ov});
        chk({tag, " R2 sovf"}, {31'd0, sovf}, {31'd0, sh_so});
    endtask

    task automatic t_reset();
        chk("R1 result", result, 32'd0);
        chk("R1 mq", mq, 32'd0);
        chk("R1 flags", {26'd0, ovf, sovf, busy, done, 2'b00}, 32'd0);
    endtask

    task automatic t_load_mul();
        apply("R10 load", 4'h6, 32'h12345678, 32'h0);
        apply("R6 mul plain", 4'h2, 32'h00012345, 32'h00010000);
        apply("R6 mul rec wide", 4'hA, 32'h00012345, 32'h00010000);
        apply("R6 mul rec neg", 4'hA, 32'hFFFFFFFD, 32'h00000007);
        apply("R10 load rec", 4'hF, 32'hCAFEF00D, 32'h0);
    endtask

    task automatic t_long_div();
        apply("R3 set mq", 4'h6, 32'h00000010, 32'h0);
        apply("R3 long pos", 4'h8, 32'h00000001, 32'h00000100);
        apply("R3 set mq2", 4'h6, 32'h00000000, 32'h0);
        apply("R3 long neg", 4'h8, 32'hFFFFFFFF, 32'h00000007);
        apply("R3 set mq3", 4'h6, 32'h80000000, 32'h0);
        apply("R3 long q overflow", 4'h8, 32'h00000000, 32'h00000001);
    endtask

    task automatic t_div_special();
        apply("R4 long by zero", 4'h8, 32'h80000005, 32'h0);
        apply("R4 set mq", 4'h6, 32'h00000009, 32'h0);
        apply("R4 long too wide plain", 4'h0, 32'h00000005, 32'h00000003);
        apply("R4 short min by -1", 4'h9, 32'h80000000, 32'hFFFFFFFF);
        apply("R4 short by zero plain", 4'h1, 32'h00000042, 32'h0);
    endtask

    task automatic t_short_div();
        apply("R5 short neg", 4'h9, 32'hFFFFFF9C, 32'h00000007);
        apply("R5 short pos", 4'h1, 32'h000003E8, 32'hFFFFFFFD);
    endtask

    task automatic t_neg();
        apply("R7 neg min", 4'hB, 32'h80000000, 32'h0);
        apply("R7 neg five", 4'hB, 32'h00000005, 32'h0);
        apply("R7 neg min plain", 4'h3, 32'h80000000, 32'h0);
    endtask

    task automatic t_doz();
        apply("R8 doz greater", 4'hC, 32'h00000003, 32'h0000000A);
        apply("R8 doz not greater", 4'hC, 32'h0000000A, 32'h00000003);
        apply("R8 doz overflow", 4'hC, 32'h80000000, 32'h00000001);
    endtask

    task automatic t_mask();
        apply("R9 mask run", 4'h5, 32'h00000003, 32'h0000000A);
        apply("R9 mask wrap", 4'h5, 32'h0000000A, 32'h00000003);
        apply("R9 mask all", 4'hD, 32'h00000005, 32'h00000004);
        apply("R9 mask single", 4'h5, 32'h00000007, 32'h00000007);
    endtask

    task automatic t_sticky();
        apply("R11 set", 4'hB, 32'h80000000, 32'h0);
        apply("R11 ovf cleared sovf kept", 4'hB, 32'h00000001, 32'h0);
        @(negedge clk);
        sovf_clr = 1'b1;
        @(negedge clk);
        sovf_clr = 1'b0;
        sh_so = 1'b0;
        chk("R11 cleared by input", {31'd0, sovf}, 32'd0);
        apply("R2 plain op keeps flags", 4'h3, 32'h80000000, 32'h0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] er, em;
        logic eov;
        int elat, lat;
        apply("R13 set mq", 4'h6, 32'h00000123, 32'h0);
        model(4'h0, 32'h00000002, 32'h00000011, sh_mq, er, em, eov, elat);
        @(negedge clk);
        op = 4'h0; a = 32'h00000002; b = 32'h00000011; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        chk("R12 busy during divide", {31'd0, busy}, 32'd1);
        repeat (4) begin @(negedge clk); lat++; end
        op = 4'h6; a = 32'h0000DEAD; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat++;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        sh_mq = em;
        chk("R13 latency unchanged", 32'(lat), 32'(elat));
        chk("R13 divide result", result, er);
        chk("R13 divide remainder", mq, em);
        repeat (3) begin
            @(negedge clk);
            chk("R13 no extra done", {31'd0, done}, 32'd0);
        end
        chk("R13 mq untouched", mq, em);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_mul();
        t_long_div();
        t_div_special();
        t_short_div();
        t_neg();
        t_doz();
        t_mask();
        t_sticky();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule